// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for the management face of a 10/100 Ethernet PHY as a MAC's host sees it. It keeps sixteen 16-bit PHY registers that have fixed reset contents, some read-only entries, a control register whose reset bit restores defaults instead of being stored, and status and partner-ability bits driven by an external link-state input. A host reaches these registers through a command interface. It supplies a PHY address, a register address and a data word, then issues one of three commands: a strobe that loads the transmit-data holding register and writes at once, a write-control command that writes the held word, or a read-status command that captures a register into the read-data output.

Only one PHY address answers. Any other address reads all ones and takes no writes. Register addresses beyond the sixteen implemented entries read as zero. A link-fail flag is sampled on each read-status command. While scan mode is on, every change of the link input also refreshes that flag. The serial management bit timing and the line-side signalling are not modelled.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset, registers 0..5 hold 0x1000, 0x7868, 0x2000, 0x5C90, 0x01E1 and 0x0000, and the other registers hold 0. rd_data and link_fail are 0, and the held transmit word is 0.
- R2: A read-status command to any PHY address other than PHY_ADDR (default 1) returns 0xFFFF. Writes to such an address change no register.
- R3: Registers 1, 2 and 3 are read-only. Writes to them leave their contents unchanged.
- R4: A write to register 0 with bit 15 set restores every register to its R1 value and then reapplies the current link input as in R5/R6. The written value is not stored.
- R5: When link_up rises, bit 2 of register 1 is set and register 5 is ORed with 0x01E1. The change takes effect at the first clock edge that sees the new level.
- R6: When link_up falls, bit 2 of register 1 is cleared and register 5 is ANDed with 0x01FF.
- R7: A read-status command loads the addressed register into rd_data at the next edge. At that same edge it loads the inverse of link_up into link_fail.
- R8: A data-write strobe stores wr_data in the held transmit word. If the PHY address matches, the same strobe writes wr_data to the addressed register.
- R9: A write-control command writes the held transmit word to the addressed register when the PHY address matches.
- R10: While scan_en is high, a change of link_up sets link_fail to the inverse of link_up at that edge. While scan_en is low, link changes leave link_fail alone.
- R11: Register addresses 16 and above read as 0x0000 and ignore writes. Such a write does not alias onto the register at the address modulo 16.
- R12: Registers that are neither read-only nor register 0 store all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_addr | input | 5 | PHY address of the command |
| reg_addr | input | 5 | Register address of the command |
| wr_data | input | 16 | Data for the data-write strobe |
| data_wr_stb | input | 1 | Load held word and write it at once |
| wr_ctrl_cmd | input | 1 | Write the held word |
| rd_stat_cmd | input | 1 | Capture register and link state |
| scan_en | input | 1 | Link changes refresh link_fail |
| link_up | input | 1 | Current link state |
| rd_data | output | 16 | Captured register contents |
| link_fail | output | 1 | Captured link-down flag |

## Verification
The bench loads a register through a foreign PHY address and then reads it back. A design that decodes only the register address would show the foreign data. A write to address 20 is followed by a read of register 4, which catches a design that truncates the address and aliases the write. The bench drops the link after filling register 5 with ones, so a mask of the wrong width or a full clear gives a value other than 0x01FF. It also fires the soft reset while the link is up, which exposes a design that restores defaults but forgets to reapply the link bits. Toggling the link with scan mode off and then on shows whether link_fail ignores scan_en.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;

    localparam int DW   = 16;
    localparam int NREG = 16;

    localparam int IDX_CTL    = 0;
    localparam int IDX_STAT   = 1;
    localparam int IDX_ID_HI  = 2;
    localparam int IDX_ID_LO  = 3;
    localparam int IDX_ADV    = 4;
    localparam int IDX_PARTNR = 5;

    localparam int CTL_SOFT_RST_BIT = 15;
    localparam int STAT_LINK_BIT    = 2;

    localparam logic [DW-1:0] CTL_INIT    = 16'h1000;
    localparam logic [DW-1:0] STAT_INIT   = 16'h7868;
    localparam logic [DW-1:0] ID_HI_INIT  = 16'h2000;
    localparam logic [DW-1:0] ID_LO_INIT  = 16'h5C90;
    localparam logic [DW-1:0] ADV_INIT    = 16'h01E1;
    localparam logic [DW-1:0] PARTNR_UP   = 16'h01E1;
    localparam logic [DW-1:0] PARTNR_KEEP = 16'h01FF;

    typedef logic [DW-1:0] word_t;

    function automatic word_t init_word(input int idx);
        case (idx)
            IDX_CTL:   return CTL_INIT;
            IDX_STAT:  return STAT_INIT;
            IDX_ID_HI: return ID_HI_INIT;
            IDX_ID_LO: return ID_LO_INIT;
            IDX_ADV:   return ADV_INIT;
            default:   return '0;
        endcase
    endfunction

    function automatic logic is_read_only(input int idx);
        return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
    endfunction

endpackage

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import phymgmt_pkg::*;
#(
    parameter int N_REGS = NREG,
    parameter int IW     = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  word_t         wr_val,
    input  logic          link_up,
    input  logic [IW-1:0] rd_idx,
    output word_t         rd_val
);

    typedef struct packed {
        logic [N_REGS-1:0][DW-1:0] r;
        logic                      link;
    } rf_state_t;

    rf_state_t st_q, st_d;

    function automatic rf_state_t defaults_state();
        rf_state_t s;
        for (int i = 0; i < N_REGS; i++) begin
            s.r[i] = init_word(i);
        end
        s.link = 1'b0;
        return s;
    endfunction

    function automatic rf_state_t apply_link(input rf_state_t s, input logic up);
        rf_state_t o;
        o = s;
        if (up) begin
            o.r[IDX_STAT][STAT_LINK_BIT] = 1'b1;
            o.r[IDX_PARTNR] = s.r[IDX_PARTNR] | PARTNR_UP;
        end else begin
            o.r[IDX_STAT][STAT_LINK_BIT] = 1'b0;
            o.r[IDX_PARTNR] = s.r[IDX_PARTNR] & PARTNR_KEEP;
        end
        o.link = up;
        return o;
    endfunction

    logic soft_rst;
    logic link_chg;

    always_comb begin
        soft_rst = wr_en && (int'(wr_idx) == IDX_CTL) && wr_val[CTL_SOFT_RST_BIT];
        link_chg = (link_up != st_q.link);
        st_d     = st_q;
        if (soft_rst) begin
            st_d = apply_link(defaults_state(), link_up);
        end else begin
            if (wr_en && !is_read_only(int'(wr_idx))) begin
                st_d.r[wr_idx] = wr_val;
            end
            if (link_chg) begin
                st_d = apply_link(st_d, link_up);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= defaults_state();
        else        st_q <= st_d;
    end

    assign rd_val = st_q.r[rd_idx];

    AST_LINK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up != st_q.link) |=> (st_q.r[IDX_STAT][STAT_LINK_BIT] == $past(link_up))); // R5
    AST_RO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) == IDX_STAT && link_up == st_q.link) |=> $stable(st_q.r[IDX_STAT])); // R3
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.r[IDX_CTL] == CTL_INIT)); // R4
    AST_LINK_DOWN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && st_q.link && !wr_en) |=> (st_q.r[IDX_PARTNR][15:9] == 7'd0)); // R6

endmodule

// File: rtl/mgmt_host.sv
module mgmt_host
    import phymgmt_pkg::*;
#(
    parameter int PHY_ADDR = 1,
    parameter int AW       = 5,
    parameter int N_REGS   = NREG,
    parameter int IW       = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] phy_addr,
    input  logic [AW-1:0] reg_addr,
    input  word_t         wr_data,
    input  logic          data_wr_stb,
    input  logic          wr_ctrl_cmd,
    input  logic          rd_stat_cmd,
    input  logic          scan_en,
    input  logic          link_up,
    input  word_t         rd_val,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output word_t         wr_val,
    output logic [IW-1:0] rd_idx,
    output word_t         rd_data,
    output logic          link_fail
);

    localparam logic [AW-1:0] MY_ADDR = AW'(PHY_ADDR);
    localparam logic [AW:0]   REG_LIM = (AW+1)'(N_REGS);
    localparam word_t         NO_PHY  = '1;

    typedef struct packed {
        word_t txd;
        word_t rdd;
        logic  lf;
        logic  link_seen;
    } host_state_t;

    host_state_t st_q, st_d;
    logic        hit;
    logic        in_range;

    always_comb begin
        hit      = (phy_addr == MY_ADDR);
        in_range = ({1'b0, reg_addr} < REG_LIM);
        wr_idx   = reg_addr[IW-1:0];
        rd_idx   = reg_addr[IW-1:0];
        wr_val   = data_wr_stb ? wr_data : st_q.txd;
        wr_en    = hit && in_range && (data_wr_stb || wr_ctrl_cmd);

        st_d           = st_q;
        st_d.link_seen = link_up;
        if (data_wr_stb) st_d.txd = wr_data;
        if (rd_stat_cmd) begin
            if (!hit)          st_d.rdd = NO_PHY;
            else if (in_range) st_d.rdd = rd_val;
            else               st_d.rdd = '0;
            st_d.lf = !link_up;
        end
        if (scan_en && (link_up != st_q.link_seen)) st_d.lf = !link_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rdd;
    assign link_fail = st_q.lf;

    AST_FOREIGN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_cmd && phy_addr != MY_ADDR) |=> (rd_data == NO_PHY)); // R2
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_cmd && phy_addr == MY_ADDR && {1'b0, reg_addr} >= REG_LIM) |=> (rd_data == '0)); // R11
    AST_LF_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_cmd |=> (link_fail == !$past(link_up))); // R7
    AST_SCAN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !rd_stat_cmd) |=> $stable(link_fail)); // R10

endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
    import phymgmt_pkg::*;
#(
    parameter int PHY_ADDR = 1,
    parameter int AW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] phy_addr,
    input  logic [AW-1:0] reg_addr,
    input  logic [15:0]   wr_data,
    input  logic          data_wr_stb,
    input  logic          wr_ctrl_cmd,
    input  logic          rd_stat_cmd,
    input  logic          scan_en,
    input  logic          link_up,
    output logic [15:0]   rd_data,
    output logic          link_fail
);

    localparam int IW = $clog2(NREG);

    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;
    word_t         wr_val;
    word_t         rd_val;

    mgmt_host #(.PHY_ADDR(PHY_ADDR), .AW(AW), .N_REGS(NREG), .IW(IW)) u_host (
        .clk(clk), .rst_n(rst_n),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .data_wr_stb(data_wr_stb), .wr_ctrl_cmd(wr_ctrl_cmd),
        .rd_stat_cmd(rd_stat_cmd), .scan_en(scan_en), .link_up(link_up),
        .rd_val(rd_val), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .rd_idx(rd_idx), .rd_data(rd_data), .link_fail(link_fail)
    );

    mgmt_regfile #(.N_REGS(NREG), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .link_up(link_up), .rd_idx(rd_idx), .rd_val(rd_val)
    );

endmodule

// File: tb/sim_phy_mgmt_model.sv
module sim_phy_mgmt_model;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        data_wr_stb = 1'b0;
    logic        wr_ctrl_cmd = 1'b0;
    logic        rd_stat_cmd = 1'b0;
    logic        scan_en = 1'b0;
    logic        link_up = 1'b0;
    logic [15:0] rd_data;
    logic        link_fail;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] exp_data_q [$];
    logic        exp_lf_q   [$];
    string       exp_tag_q  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_mgmt_model u0 (
        .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_data(wr_data), .data_wr_stb(data_wr_stb), .wr_ctrl_cmd(wr_ctrl_cmd),
        .rd_stat_cmd(rd_stat_cmd), .scan_en(scan_en), .link_up(link_up),
        .rd_data(rd_data), .link_fail(link_fail)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] pa, input logic [4:0] ra,
                      input logic [15:0] exp, input logic lf, input string tag);
        phy_addr = pa; reg_addr = ra; rd_stat_cmd = 1'b1;
        exp_data_q.push_back(exp); exp_lf_q.push_back(lf); exp_tag_q.push_back(tag);
        @(negedge clk);
        rd_stat_cmd = 1'b0;
    endtask

    task automatic wr_now(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        phy_addr = pa; reg_addr = ra; wr_data = d; data_wr_stb = 1'b1;
        @(negedge clk);
        data_wr_stb = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [4:0] pa, input logic [4:0] ra);
        phy_addr = pa; reg_addr = ra; wr_ctrl_cmd = 1'b1;
        @(negedge clk);
        wr_ctrl_cmd = 1'b0;
    endtask

    task automatic set_link(input logic up);
        link_up = up;
        @(negedge clk);
    endtask

    // monitor: pops expected items one cycle after each read command
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && rd_stat_cmd) begin
                @(negedge clk);
                if (exp_data_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected read result actual=%h expected=none", rd_data);
                end else begin
                    chk(rd_data, exp_data_q.pop_front(), exp_tag_q[0]);
                    chk({15'd0, link_fail}, {15'd0, exp_lf_q.pop_front()},
                        {exp_tag_q.pop_front(), " R7 link_fail"});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data, 16'h0000, "R1 rd_data after reset");
        chk({15'd0, link_fail}, 16'd0, "R1 link_fail after reset");
        // R1 reset contents, link down
        rd(5'd1, 5'd0, 16'h1000, 1'b1, "R1 ctl");
        rd(5'd1, 5'd1, 16'h7868, 1'b1, "R1 status");
        rd(5'd1, 5'd2, 16'h2000, 1'b1, "R1 id hi");
        rd(5'd1, 5'd3, 16'h5C90, 1'b1, "R1 id lo");
        rd(5'd1, 5'd4, 16'h01E1, 1'b1, "R1 adv");
        rd(5'd1, 5'd5, 16'h0000, 1'b1, "R1 partner");
        rd(5'd1, 5'd9, 16'h0000, 1'b1, "R1 other");
        // R5 link up
        set_link(1'b1);
        rd(5'd1, 5'd1, 16'h786C, 1'b0, "R5 status link bit");
        rd(5'd1, 5'd5, 16'h01E1, 1'b0, "R5 partner bits");
        // R8 immediate write
        wr_now(5'd1, 5'd4, 16'hABCD);
        rd(5'd1, 5'd4, 16'hABCD, 1'b0, "R8 data strobe write");
        // R2 foreign write ignored but word held; R9 write-control
        wr_now(5'd3, 5'd4, 16'h1234);
        rd(5'd1, 5'd4, 16'hABCD, 1'b0, "R2 foreign write ignored");
        rd(5'd3, 5'd0, 16'hFFFF, 1'b0, "R2 foreign read ones");
        wr_ctrl(5'd1, 5'd7);
        rd(5'd1, 5'd7, 16'h1234, 1'b0, "R9 write-control held word");
        wr_ctrl(5'd2, 5'd8);
        rd(5'd1, 5'd8, 16'h0000, 1'b0, "R2 foreign write-control ignored");
        // R3 read-only
        wr_now(5'd1, 5'd1, 16'h0000);
        wr_now(5'd1, 5'd2, 16'hFFFF);
        wr_now(5'd1, 5'd3, 16'h0000);
        rd(5'd1, 5'd1, 16'h786C, 1'b0, "R3 status read-only");
        rd(5'd1, 5'd2, 16'h2000, 1'b0, "R3 id hi read-only");
        rd(5'd1, 5'd3, 16'h5C90, 1'b0, "R3 id lo read-only");
        // R11 high addresses
        wr_now(5'd1, 5'd20, 16'h5555);
        rd(5'd1, 5'd20, 16'h0000, 1'b0, "R11 high address reads zero");
        rd(5'd1, 5'd4, 16'hABCD, 1'b0, "R11 no alias write");
        // R12 full width
        wr_now(5'd1, 5'd15, 16'hFFFF);
        rd(5'd1, 5'd15, 16'hFFFF, 1'b0, "R12 full width store");
        // R6 link down
        wr_now(5'd1, 5'd5, 16'hFFFF);
        set_link(1'b0);
        rd(5'd1, 5'd5, 16'h01FF, 1'b1, "R6 partner masked");
        rd(5'd1, 5'd1, 16'h7868, 1'b1, "R6 status link cleared");
        // R10 scan off then on
        set_link(1'b1);
        chk({15'd0, link_fail}, 16'd1, "R10 scan off holds link_fail");
        scan_en = 1'b1;
        set_link(1'b0);
        chk({15'd0, link_fail}, 16'd1, "R10 scan on link down");
        set_link(1'b1);
        chk({15'd0, link_fail}, 16'd0, "R10 scan on link up");
        scan_en = 1'b0;
        // R4 soft reset with link up
        wr_now(5'd1, 5'd0, 16'h8000);
        rd(5'd1, 5'd0, 16'h1000, 1'b0, "R4 ctl restored");
        rd(5'd1, 5'd1, 16'h786C, 1'b0, "R4 link reapplied status");
        rd(5'd1, 5'd5, 16'h01E1, 1'b0, "R4 link reapplied partner");
        rd(5'd1, 5'd4, 16'h01E1, 1'b0, "R4 adv restored");
        rd(5'd1, 5'd7, 16'h0000, 1'b0, "R4 plain cleared");
        wr_now(5'd1, 5'd0, 16'h0100);
        rd(5'd1, 5'd0, 16'h0100, 1'b0, "R12 ctl stores without reset bit");
        @(negedge clk);
        @(negedge clk);
        chk(16'(exp_data_q.size()), 16'd0, "R7 all reads returned");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule